// File: doc/BRIEF.md
# Serial Clock Generator with Settling Flag

This block produces the serial clock for a serial flash controller. It derives that clock from a faster base clock under the control of one register. The register holds three things: a gate bit that turns the serial clock on or off, a divide value, and a read-only flag that reports whether the output rate has settled. Each half of the output period lasts as many base cycles as the divide value, so the output frequency is the base frequency divided by twice the divider. Besides the clock, the block gives the shift logic a one-cycle tick on every rising edge of the serial clock.

When software writes a divider that differs from the one already held, the settled flag drops at once. The new ratio is not applied in the middle of a phase. It is applied at the next half-period boundary, so the output never shows a shortened pulse. The flag rises again after the new ratio has run for two complete output periods. If the clock is gated off, the flag rises a few base cycles after the load instead. Software is expected to poll the flag after each change of rate before it starts a transfer.

Top module: `sck_clock_gen`

## Requirements
- R1: The register is 16 bits wide. Bit 0 is the clock gate and bits 15:8 hold the divide value; both read back as written. Bit 1 reads the settled flag, and bits 7:2 always read 0.
- R2: While bit 0 is 0, the serial clock is held low from the next cycle onward and no tick is produced.
- R3: With divide value D (1..255) and the gate on, the serial clock stays high for D base cycles and low for D base cycles, so its period is 2·D cycles.
- R4: The tick is high for exactly one base cycle, in the same cycle in which the serial clock goes from low to high.
- R5: A write whose divide field differs from the held value makes bit 1 read 0 in the next cycle. A write with the same divide field leaves bit 1 unchanged.
- R6: A divide value of 0 acts as 1, giving a period of 2 base cycles, and the field still reads back as 0.
- R7: A new divide value takes effect only at a half-period boundary. While the gate is on, the first output edge after the write still uses the old ratio, and it is at that edge that the new ratio is loaded.
- R8: While the gate is on, the settled flag rises in the same cycle as the fourth output edge after the load, which is the fifth output edge after the write. While the gate is off, the load happens on the first cycle after the write and the flag rises four cycles after that, five cycles after the write.
- R9: Bit 1 cannot be written. Writing 1 to it does not set the flag, and writing 0 to it does not clear the flag.
- R10: A synchronous reset clears the gate, loads a divide value of 1 and clears the flag. The register then reads 0x0100, and with the gate off the flag rises on the fourth clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 16 | Write data for the control register |
| ctl_rdata | output | 16 | Current contents of the control register |
| sck | output | 1 | Serial clock; idles low |
| sck_tick | output | 1 | One-cycle pulse on each rising edge of sck |

## Verification
If the active-ratio register or the phase counter holds a wrong value, the very next half period has the wrong length. The bench measures the high time and the full period at the ports after every change of rate, so such an error shows within one output period. If the settle counter is off, the flag rises on the wrong output edge or on the wrong base cycle. The bench counts the output edges, or the base cycles when the clock is gated off, between each write and the rising flag, so a sequencing error shows within about five half periods of the write. A divider loaded in the middle of a phase shows up as a wrong edge count or as a short phase in the same measurement.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;
    // control register field layout (positions are software-visible)
    localparam int CTL_W      = 16;
    localparam int EN_BIT     = 0;
    localparam int STABLE_BIT = 1;
    localparam int DIV_LSB    = 8;
    localparam int RSV_LSB    = STABLE_BIT + 1;
    localparam int RSV_MSB    = DIV_LSB - 1;
endpackage

// File: rtl/sck_ctl_regs.sv
module sck_ctl_regs
    import sck_gen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             wr_en_bit,
    input  logic [DIV_W-1:0] wr_div,
    output logic             en,
    output logic [DIV_W-1:0] div,
    output logic             reload
);
    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        reload  = wr && (wr_div != state_q.div);
        if (wr) begin
            state_d.en  = wr_en_bit;
            state_d.div = wr_div;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.en  <= 1'b0;
            state_q.div <= DIV_W'(1);
        end else begin
            state_q <= state_d;
        end
    end

    assign en  = state_q.en;
    assign div = state_q.div;

    // R1: a written divide field is what the register holds next
    assert_div_held_R1: assert property (@(posedge clk) disable iff (rst)
        wr |=> (div == $past(wr_div)));

    // R2 relies on the gate following bit 0 of each write
    assert_gate_follows_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (en == $past(wr_en_bit)));
endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             reload,
    output logic             sck,
    output logic             tick,
    output logic             boundary,
    output logic             applied,
    output logic             pend
);
    typedef struct packed {
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             tick;
        logic             pend;
    } phase_t;

    phase_t state_d, state_q;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
        return (v == '0) ? DIV_W'(1) : v;
    endfunction

    always_comb begin
        state_d      = state_q;
        state_d.tick = 1'b0;
        boundary     = 1'b0;
        applied      = 1'b0;
        if (!en) begin
            state_d.cnt = '0;
            state_d.sck = 1'b0;
            if (state_q.pend) begin
                state_d.act  = eff_div(div);
                state_d.pend = 1'b0;
                applied      = 1'b1;
            end
        end else if (state_q.cnt == state_q.act - DIV_W'(1)) begin
            boundary     = 1'b1;
            state_d.cnt  = '0;
            state_d.sck  = !state_q.sck;
            state_d.tick = !state_q.sck;
            if (state_q.pend) begin
                state_d.act  = eff_div(div);
                state_d.pend = 1'b0;
                applied      = 1'b1;
            end
        end else begin
            state_d.cnt = state_q.cnt + DIV_W'(1);
        end
        // a fresh write always leaves a load pending
        if (reload) state_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.act  <= DIV_W'(1);
            state_q.cnt  <= '0;
            state_q.sck  <= 1'b0;
            state_q.tick <= 1'b0;
            state_q.pend <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sck  = state_q.sck;
    assign tick = state_q.tick;
    assign pend = state_q.pend;

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sck);

    assert_tick_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        tick |-> $rose(sck));

    assert_ratio_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        state_q.act != '0);

    assert_load_at_edge_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_q.act) |-> (!$stable(sck) || !$past(en)));
endmodule

// File: rtl/sck_settle_mon.sv
module sck_settle_mon #(
    parameter int SETTLE_STEPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic boundary,
    input  logic applied,
    input  logic pend,
    input  logic reload,
    output logic stable
);
    localparam int CW = (SETTLE_STEPS > 1) ? $clog2(SETTLE_STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_STEPS - 1);

    typedef struct packed {
        logic          stable;
        logic [CW-1:0] cnt;
    } settle_t;

    settle_t state_d, state_q;
    logic    step;

    always_comb begin
        state_d = state_q;
        // gated on: count output half periods; gated off: count base cycles
        step    = en ? boundary : 1'b1;
        if (reload) begin
            state_d.stable = 1'b0;
            state_d.cnt    = '0;
        end else if (applied) begin
            state_d.cnt = '0;
        end else if (!state_q.stable && !pend && step) begin
            if (state_q.cnt == LAST) state_d.stable = 1'b1;
            else                     state_d.cnt    = state_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.stable <= 1'b0;
            state_q.cnt    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stable = state_q.stable;

    assert_change_clears_R5: assert property (@(posedge clk) disable iff (rst)
        reload |=> !stable);

    assert_no_rise_while_pending_R8: assert property (@(posedge clk) disable iff (rst)
        pend |=> !$rose(stable));
endmodule

// File: rtl/sck_clock_gen.sv
module sck_clock_gen
    import sck_gen_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int SETTLE_STEPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             sck,
    output logic             sck_tick
);
    logic             en;
    logic [DIV_W-1:0] div;
    logic             reload;
    logic             boundary;
    logic             applied;
    logic             pend;
    logic             stable;

    sck_ctl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctl_wr),
        .wr_en_bit (ctl_wdata[EN_BIT]),
        .wr_div    (ctl_wdata[DIV_LSB +: DIV_W]),
        .en        (en),
        .div       (div),
        .reload    (reload)
    );

    sck_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .div      (div),
        .reload   (reload),
        .sck      (sck),
        .tick     (sck_tick),
        .boundary (boundary),
        .applied  (applied),
        .pend     (pend)
    );

    sck_settle_mon #(.SETTLE_STEPS(SETTLE_STEPS)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .boundary (boundary),
        .applied  (applied),
        .pend     (pend),
        .reload   (reload),
        .stable   (stable)
    );

    always_comb begin
        ctl_rdata                     = '0;
        ctl_rdata[EN_BIT]             = en;
        ctl_rdata[STABLE_BIT]         = stable;
        ctl_rdata[DIV_LSB +: DIV_W]   = div;
    end

    assert_settle_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(stable) && $past(en)) |-> (sck != $past(sck)));

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && (ctl_wdata[RSV_MSB:RSV_LSB] != '0)) |=> (ctl_rdata[RSV_MSB:RSV_LSB] == '0));

    assert_flag_not_writable_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[STABLE_BIT] && !stable) |=> !stable);
endmodule

// File: tb/sim_sck_clock_gen.sv
module sim_sck_clock_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        sck;
    logic        sck_tick;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    sck_clock_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .sck       (sck),
        .sck_tick  (sck_tick)
    );

    // {divide value written, expected half-period length}
    localparam logic [15:0] VEC [8] = '{
        16'h0101, 16'h0202, 16'h0303, 16'h0001,
        16'h0505, 16'h0808, 16'hFFFF, 16'h0404
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        int h;
        int tog;
        logic prev;

        // R10: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset readback", int'(ctl_rdata), 32'h0100);
        chk("R10 sck idle after reset", int'(sck), 0);
        n = 0;
        while (!ctl_rdata[1]) begin
            @(negedge clk);
            n++;
        end
        chk("R10 flag rise cycles after reset", n, 4);

        // table of rates, all with the gate on
        for (int i = 0; i < 8; i++) begin
            logic [7:0] dv;
            int half;
            logic changed;
            dv      = VEC[i][15:8];
            half    = int'(VEC[i][7:0]);
            changed = (i != 0);
            wr_reg({dv, 8'h01});
            if (changed) begin
                chk("R5 flag cleared by new divider", int'(ctl_rdata[1]), 0);
                prev = sck;
                tog  = 0;
                while (!ctl_rdata[1]) begin
                    @(negedge clk);
                    if (sck != prev) tog++;
                    prev = sck;
                end
                chk("R7 R8 output edges from write to flag", tog, 5);
            end else begin
                chk("R5 same divider keeps flag", int'(ctl_rdata[1]), 1);
            end
            chk("R1 R6 readback", int'(ctl_rdata), int'({dv, 6'b0, 2'b11}));
            while (!sck_tick) @(negedge clk);
            h = 1;
            @(negedge clk);
            chk("R4 tick lasts one cycle", int'(sck_tick), 0);
            while (sck) begin
                h++;
                @(negedge clk);
            end
            chk("R3 R6 high time", h, half);
            while (!sck_tick) @(negedge clk);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!sck_tick);
            chk("R3 R6 period", n, 2 * half);
        end

        // R2 / R8: gate off with a new divider
        wr_reg(16'h0900);
        chk("R5 flag cleared while gated", int'(ctl_rdata[1]), 0);
        n = 0;
        while (!ctl_rdata[1]) begin
            @(negedge clk);
            n++;
        end
        chk("R8 gated flag rise cycles", n, 5);
        h = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck || sck_tick) h++;
        end
        chk("R2 no clock or tick while gated", h, 0);

        // R9: flag bit ignores writes
        wr_reg(16'h0C02);
        chk("R9 writing one to flag", int'(ctl_rdata[1]), 0);
        while (!ctl_rdata[1]) @(negedge clk);
        wr_reg(16'h0C00);
        chk("R9 writing zero to flag", int'(ctl_rdata), 32'h0C02);
        wr_reg(16'h0CFC);
        chk("R1 reserved bits read zero", int'(ctl_rdata), 32'h0C02);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule